// File: doc/BRIEF.md
# Signed Step Counter with Overflow Hold

This block is a clocked two's-complement counter that moves by a signed step rather than by one. A synchronous load control sets the count to a signed start value. After that, each up pulse adds the signed step operand to the count, and each down pulse subtracts it.

Before any update is committed, the block checks whether the new value would fall outside the signed range of the count. If it would, the count keeps its value and a sticky overflow flag is set. Because of this, a run of requests in one direction stops at the last value that still fits and never wraps around.

The up and down inputs are single-cycle pulses produced by logic outside the block. An asynchronous active-low reset clears the count and the flag. The reset is released in step with the clock.

Top module: `sstep_counter`

## Requirements
- R1: While `rst_n` is low, `q` reads 0 and `ovf` reads 0 at once, without waiting for a clock edge. After `rst_n` rises, the block ignores every control until two clock edges have passed, while the reset release is brought into step with the clock.
- R2: When `load` is high at a rising edge, `q` takes the value of `a` and `ovf` clears after that edge. `load` wins over `up` and `dn` in the same cycle.
- R3: When `up`=1, `dn`=0 and `load`=0, `q` becomes `q + b`, read as signed W-bit values, provided the true sum lies in [-2^(W-1), 2^(W-1)-1]. A negative `b` moves `q` downward.
- R4: When `dn`=1, `up`=0 and `load`=0, `q` becomes `q - b` when the true difference is in range. The negated step is formed as the bitwise inverse plus one, so `b` = -2^(W-1) is valid whenever the difference fits.
- R5: When a requested add or subtract would give a true result outside the W-bit signed range, `q` keeps its value and `ovf` becomes 1. An add overflows exactly when both operands share a sign and the W-bit result has the other sign. A subtract overflows exactly when the operands' signs differ and the result's sign differs from that of `q`.
- R6: `ovf` stays 1 until the next `load` or reset. Later steps whose results fit still update `q`.
- R7: When `up` and `dn` are both high, or both low, and `load` is low, neither `q` nor `ovf` changes.
- R8: The width W is a parameter with a default of 8. Every operand and intermediate value is sign-extended, never zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Synchronous load of the start value |
| up | input | 1 | One-cycle request to add the step |
| dn | input | 1 | One-cycle request to subtract the step |
| a | input | W | Signed start value |
| b | input | W | Signed step |
| q | output | W | Signed count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The tests run four load-then-repeat runs until the count stops moving:
- a positive step counted up to the top limit;
- a positive step counted down to exactly the most negative value;
- a negative step counted up, so the count falls to the bottom;
- a negative step counted down, so the count rises to the top.

Between them, these runs separate the add rule from the subtract rule and the operand sign checks from the result sign check. The most negative step is applied both where its subtraction fits and where it overflows. This shows whether negation is done in W bits without loss. Further tests cover simultaneous requests, load priority, the sticky flag during later in-range steps, and an asynchronous reset in the middle of a run.

// File: rtl/sstep_pkg.sv
package sstep_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } step_op_e;
endpackage

// File: rtl/sstep_req_decode.sv
module sstep_req_decode
  import sstep_pkg::*;
(
  input  logic     load_i,
  input  logic     up_i,
  input  logic     dn_i,
  output step_op_e op_o
);
  // Load wins; simultaneous or absent requests hold.
  always_comb begin
    op_o = OP_HOLD;
    if (!load_i) begin
      if (up_i && !dn_i)      op_o = OP_ADD;
      else if (dn_i && !up_i) op_o = OP_SUB;
    end
  end
endmodule

// File: rtl/sstep_arith.sv
module sstep_arith
  import sstep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic signed [W-1:0] q_i,
  input  logic signed [W-1:0] b_i,
  input  step_op_e            op_i,
  output logic signed [W-1:0] res_o,
  output logic                step_ovf_o
);
  localparam int MSB = W - 1;

  logic signed [W-1:0] opnd;
  logic                cin;
  logic                q_s, b_s, r_s;

  // Subtract as q + ~b + 1, kept within W bits.
  always_comb begin
    opnd  = (op_i == OP_SUB) ? ~b_i : b_i;
    cin   = (op_i == OP_SUB);
    res_o = q_i + opnd + W'(cin);
  end

  assign q_s = q_i[MSB];
  assign b_s = b_i[MSB];
  assign r_s = res_o[MSB];

  always_comb begin
    unique case (op_i)
      OP_ADD:  step_ovf_o = (q_s == b_s) && (r_s != q_s);
      OP_SUB:  step_ovf_o = (q_s != b_s) && (r_s != q_s);
      default: step_ovf_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sstep_state.sv
module sstep_state
  import sstep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic signed [W-1:0] a_i,
  input  step_op_e            op_i,
  input  logic signed [W-1:0] res_i,
  input  logic                step_ovf_i,
  output logic signed [W-1:0] q_o,
  output logic                ovf_o
);
  logic signed [W-1:0] q_nxt;
  logic                ovf_nxt;
  logic                q_en;

  always_comb begin
    q_nxt   = q_o;
    ovf_nxt = ovf_o;
    q_en    = 1'b0;
    if (load_i) begin
      q_nxt   = a_i;
      ovf_nxt = 1'b0;
      q_en    = 1'b1;
    end else if (op_i != OP_HOLD) begin
      q_en = 1'b1;
      if (step_ovf_i) ovf_nxt = 1'b1;
      else            q_nxt   = res_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o   <= '0;
      ovf_o <= 1'b0;
    end else if (q_en) begin
      q_o   <= q_nxt;
      ovf_o <= ovf_nxt;
    end
  end

  AST_LOAD_TAKES_A: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(a_i)) && !ovf_o) else $error("load");              // R2
  AST_HOLD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && op_i != OP_HOLD && step_ovf_i) |=> $stable(q_o) && ovf_o) else $error("hold"); // R5
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !load_i) |=> ovf_o) else $error("sticky");                         // R6
endmodule

// File: rtl/sstep_counter.sv
module sstep_counter
  import sstep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                up,
  input  logic                dn,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] q,
  output logic                ovf
);
  logic [1:0]          rst_sync;
  logic                rst_n_int;
  logic                load_g, up_g, dn_g;
  step_op_e            op;
  logic signed [W-1:0] res;
  logic                step_ovf;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign load_g = load & rst_n_int;
  assign up_g   = up   & rst_n_int;
  assign dn_g   = dn   & rst_n_int;

  sstep_req_decode u_dec (
    .load_i (load_g),
    .up_i   (up_g),
    .dn_i   (dn_g),
    .op_o   (op)
  );

  sstep_arith #(.W(W)) u_arith (
    .q_i        (q),
    .b_i        (b),
    .op_i       (op),
    .res_o      (res),
    .step_ovf_o (step_ovf)
  );

  sstep_state #(.W(W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_i     (load_g),
    .a_i        (a),
    .op_i       (op),
    .res_i      (res),
    .step_ovf_i (step_ovf),
    .q_o        (q),
    .ovf_o      (ovf)
  );

  // Widened, sign-extended reference for the range check.
  logic signed [W:0] wide_add, wide_sub;
  assign wide_add = $signed({q[W-1], q}) + $signed({b[W-1], b});
  assign wide_sub = $signed({q[W-1], q}) - $signed({b[W-1], b});

  AST_ADD_RANGE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op == OP_ADD) |-> (step_ovf == (wide_add[W] != wide_add[W-1]))) else $error("add range"); // R5
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op == OP_SUB) |-> (step_ovf == (wide_sub[W] != wide_sub[W-1]))) else $error("sub range"); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!load && (up == dn)) |=> $stable(q) && $stable(ovf)) else $error("idle");                 // R7
endmodule

// File: tb/sstep_counter_bench.sv
module sstep_counter_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 127;
  localparam int MINV = -128;

  logic                clk = 1'b0;
  logic                rst_n, load, up, dn;
  logic signed [W-1:0] a, b;
  logic signed [W-1:0] q;
  logic                ovf;

  int checks = 0;
  int errors = 0;
  int exp_q  = 0;
  bit exp_o  = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sstep_counter #(.W(W)) u_sstep_counter (
    .clk(clk), .rst_n(rst_n), .load(load), .up(up), .dn(dn),
    .a(a), .b(b), .q(q), .ovf(ovf)
  );

  task automatic check(input string tag);
    checks++;
    if (int'(q) != exp_q || ovf !== exp_o) begin
      errors++;
      $display("FAIL %s: q=%0d ovf=%0b expected q=%0d ovf=%0b",
               tag, q, ovf, exp_q, exp_o);
    end
  endtask

  task automatic pulse(input bit l, input bit u, input bit d);
    @(negedge clk);
    load = l; up = u; dn = d;
    @(negedge clk);
    load = 0; up = 0; dn = 0;
  endtask

  task automatic do_load(input int av, input string tag);
    a = W'(av);
    pulse(1, 0, 0);
    exp_q = av; exp_o = 0;
    check(tag);
  endtask

  // Model one step from the requirements using wide integer arithmetic.
  task automatic model_step(input bit is_up, input int bv);
    int r;
    r = is_up ? exp_q + bv : exp_q - bv;
    if (r > MAXV || r < MINV) exp_o = 1;
    else exp_q = r;
  endtask

  task automatic run_until_stop(input int av, input int bv, input bit is_up, input string tag);
    do_load(av, {tag, " R2 load"});
    b = W'(bv);
    for (int i = 0; i < 20; i++) begin
      model_step(is_up, bv);
      pulse(0, is_up, !is_up);
      check(is_up ? {tag, " R3/R5 up"} : {tag, " R4/R5 dn"});
    end
  endtask

  task automatic t_reset();
    rst_n = 0; load = 0; up = 0; dn = 0; a = 0; b = 0;
    #(CLK_PERIOD*2 + 1);
    exp_q = 0; exp_o = 0;
    check("R1 reset state");
    @(negedge clk); rst_n = 1;
    a = 8'sd55;
    load = 1;
    @(negedge clk);
    load = 0;
    exp_q = 0; exp_o = 0;
    check("R1 load ignored during reset release");
    repeat (2) @(negedge clk);
  endtask

  task automatic t_min_step();
    do_load(-1, "R4 load -1");
    b = -8'sd128;
    model_step(0, -128);
    pulse(0, 0, 1);
    check("R4 dn by -128 fits (127)");
    do_load(0, "R4 load 0");
    model_step(0, -128);
    pulse(0, 0, 1);
    check("R5 dn by -128 from 0 overflows");
  endtask

  task automatic t_both_idle();
    do_load(10, "R7 load 10");
    b = 8'sd3;
    pulse(0, 1, 1);
    check("R7 up and dn together hold");
    pulse(0, 0, 0);
    check("R7 no request holds");
  endtask

  task automatic t_load_priority();
    do_load(20, "R2 load 20");
    a = -8'sd7; b = 8'sd5;
    pulse(1, 1, 0);
    exp_q = -7; exp_o = 0;
    check("R2 load beats up");
  endtask

  task automatic t_sticky();
    do_load(120, "R6 load 120");
    b = 8'sd10;
    model_step(1, 10);
    pulse(0, 1, 0);
    check("R5 up past top holds");
    model_step(0, 10);
    pulse(0, 0, 1);
    check("R6 flag stays while q moves down");
    do_load(4, "R6 load clears flag");
  endtask

  task automatic t_async_reset();
    do_load(33, "R1 load 33");
    @(negedge clk);
    #2 rst_n = 0;
    #1;
    exp_q = 0; exp_o = 0;
    check("R1 async clear mid-cycle");
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    run_until_stop(53, 13, 1, "pos step up");
    run_until_stop(-17, 37, 0, "pos step dn");
    run_until_stop(29, -17, 1, "neg step up R8");
    run_until_stop(-47, -43, 0, "neg step dn R8");
    t_min_step();
    t_both_idle();
    t_load_priority();
    t_sticky();
    t_async_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule